// File: doc/BRIEF.md
# Flash Request Chunking Engine

This block accepts one large flash request and turns it into a series of cycles that a flash sequencer can execute. A request carries an operation (read, write or erase), a start address and a byte length. Reads and writes move through a small staging buffer that holds at most 64 bytes per cycle. No cycle may cross a 256-byte page. Erases are split into 4 KiB and 64 KiB steps, chosen by alignment and by the length still left.

For each chunk the engine fills the staging buffer from the write stream when needed. It then issues one command pulse to the sequencer and waits for a done or error pulse. After a read it empties the buffer onto the read stream. The sequencer reaches the same buffer through its own index/write/read-data port, and buffer reads on that port return data one cycle after the index is presented. The first error reported by the sequencer ends the request, and the engine then reports the address of the chunk that failed.

Top module: `flash_chunker`

## Requirements
- R1: A read or write chunk size is the least of the bytes remaining, 64, and (when the address is not a multiple of 256) the bytes up to the next multiple of 256. `cmd_count` carries that size. `cmd_cycle` is 0 for read and 1 for write.
- R2: Chunks are issued in ascending address order. Each chunk starts where the previous one ended, and together they cover exactly the requested length. With no error, `status` is 0.
- R3: The request is rejected with `status` 1 one cycle after acceptance, and no command is issued, in either of two cases: `req_op` is 3, or `req_op` is 2 (erase) and the address or the length is not a multiple of 4096. The alignment check applies even when the length is zero.
- R4: An erase step is a 64 KiB erase (`cmd_cycle` 3) when the address is a multiple of 65536 and at least 65536 bytes remain. Otherwise it is a 4 KiB erase (`cmd_cycle` 2).
- R5: Every erase command carries `cmd_count` 0.
- R6: The first `seq_err` ends the request with `status` 2. `fail_addr` then holds the address of the failing chunk, and no further command is issued.
- R7: For a write chunk, all of its bytes are taken from the write stream and placed at buffer indexes 0 to n-1 before its command pulse is issued.
- R8: For a read chunk, bytes leave on the read stream only after `seq_done`, in buffer index order. No read byte is offered while a command is outstanding.
- R9: A request of length zero (not rejected by R3) completes with `status` 0 one cycle after acceptance and issues no command.
- R10: `req_ready` is high only when idle. `busy` stays high from acceptance until completion. `done` is a one-cycle pulse, after which the engine is idle. `cmd_go` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken |
| req_op | input | 2 | 0 read, 1 write, 2 erase, 3 illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | DATA_W | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | DATA_W | Read byte |
| cmd_go | output | 1 | Start-cycle pulse to sequencer |
| cmd_cycle | output | 2 | 0 read, 1 write, 2 erase 4 KiB, 3 erase 64 KiB |
| cmd_addr | output | ADDR_W | Chunk address |
| cmd_count | output | CNT_W | Chunk byte count (0 for erase) |
| seq_done | input | 1 | Sequencer finished the cycle |
| seq_err | input | 1 | Sequencer cycle failed |
| sq_idx | input | IDX_W | Sequencer buffer index |
| sq_we | input | 1 | Sequencer buffer write |
| sq_wdata | input | DATA_W | Sequencer buffer write data |
| sq_rdata | output | DATA_W | Sequencer buffer read data, one cycle late |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| status | output | 2 | 0 ok, 1 argument error, 2 device error |
| fail_addr | output | ADDR_W | Address of the failing chunk |

## Verification
Reads and writes are swept over page offsets 0, 1, 63, 64, 65, 192, 200 and 255 combined with lengths 1, 64, 65, 130 and 257. This separates the three limits on a chunk: the 64-byte buffer, the page edge, and the tail of the request. Erases cover runs that begin unaligned to 64 KiB, runs that start with 64 KiB steps and fall back to 4 KiB steps, and pure 4 KiB runs, so the alignment rule and the length rule are each shown to decide on their own. Rejected and zero-length requests, and error injection on the first and later chunks, show where a request stops and which data has already moved by then.

// File: rtl/flash_chunk_pkg.sv
package flash_chunk_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CY_READ    = 2'd0,
    CY_WRITE   = 2'd1,
    CY_ERASE_S = 2'd2,
    CY_ERASE_L = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_ARG = 2'd1,
    ST_DEV = 2'd2
  } stat_e;

endpackage

// File: rtl/chunk_sizer.sv
// Works out the size and cycle type of the next chunk from the current
// address and the bytes still to go.
module chunk_sizer
  import flash_chunk_pkg::*;
#(
  parameter int LEN_W       = 24,
  parameter int BUF_BYTES   = 64,
  parameter int PAGE_BYTES  = 256,
  parameter int SMALL_ERASE = 4096,
  parameter int BIG_ERASE   = 65536,
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int LO_W  = $clog2(BIG_ERASE)
) (
  input  logic [1:0]       op,
  input  logic [LO_W-1:0]  addr_lo,
  input  logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] step_len,
  output logic [1:0]       step_cyc,
  output logic [CNT_W-1:0] step_cnt,
  output logic             arg_bad
);
  localparam int PAGE_LG  = $clog2(PAGE_BYTES);
  localparam int SMALL_LG = $clog2(SMALL_ERASE);
  localparam logic [LEN_W-1:0] BUF_L   = LEN_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0] PAGE_L  = LEN_W'(PAGE_BYTES);
  localparam logic [LEN_W-1:0] SMALL_L = LEN_W'(SMALL_ERASE);
  localparam logic [LEN_W-1:0] BIG_L   = LEN_W'(BIG_ERASE);

  logic [LEN_W-1:0] page_off;
  logic [LEN_W-1:0] page_left;
  logic [LEN_W-1:0] data_len;
  logic             big_fit;

  always_comb begin
    page_off  = LEN_W'(addr_lo[PAGE_LG-1:0]);
    page_left = PAGE_L - page_off;
    data_len  = (remain < BUF_L) ? remain : BUF_L;
    // the page limit only bites when the address sits inside a page
    if (page_off != '0 && page_left < data_len) data_len = page_left;

    big_fit = (addr_lo == '0) && (remain >= BIG_L);
    arg_bad = (op == OP_BAD) ||
              (op == OP_ERASE && (addr_lo[SMALL_LG-1:0] != '0 ||
                                  remain[SMALL_LG-1:0] != '0));

    if (op == OP_ERASE) begin
      step_len = big_fit ? BIG_L : SMALL_L;
      step_cyc = big_fit ? CY_ERASE_L : CY_ERASE_S;
      step_cnt = '0;
    end else begin
      step_len = data_len;
      step_cyc = (op == OP_WRITE) ? CY_WRITE : CY_READ;
      step_cnt = CNT_W'(data_len);
    end
  end

endmodule

// File: rtl/chunk_buf.sv
// Staging buffer, two synchronous ports, registered read data on both.
module chunk_buf #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_idx] <= a_wdata;
    if (b_we) mem[b_idx] <= b_wdata;
    a_q <= mem[a_idx];
    b_q <= mem[b_idx];
  end

endmodule

// File: rtl/flash_chunker.sv
module flash_chunker
  import flash_chunk_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 24,
  parameter int DATA_W      = 8,
  parameter int BUF_BYTES   = 64,
  parameter int PAGE_BYTES  = 256,
  parameter int SMALL_ERASE = 4096,
  parameter int BIG_ERASE   = 65536,
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              cmd_go,
  output logic [1:0]        cmd_cycle,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  cmd_count,
  input  logic              seq_done,
  input  logic              seq_err,
  input  logic [IDX_W-1:0]  sq_idx,
  input  logic              sq_we,
  input  logic [DATA_W-1:0] sq_wdata,
  output logic [DATA_W-1:0] sq_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int LO_W = $clog2(BIG_ERASE);

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_LOAD, S_ISSUE, S_WAIT, S_DRAIN_RD, S_DRAIN_OUT, S_STEP
  } state_e;

  state_e            state;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [LEN_W-1:0]  chunk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        cyc_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  last_idx;

  logic [LEN_W-1:0]  step_len;
  logic [1:0]        step_cyc;
  logic [CNT_W-1:0]  step_cnt;
  logic              arg_bad;
  logic [DATA_W-1:0] buf_q;

  chunk_sizer #(
    .LEN_W      (LEN_W),
    .BUF_BYTES  (BUF_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .SMALL_ERASE(SMALL_ERASE),
    .BIG_ERASE  (BIG_ERASE)
  ) u_sizer (
    .op      (op_q),
    .addr_lo (addr_q[LO_W-1:0]),
    .remain  (remain_q),
    .step_len(step_len),
    .step_cyc(step_cyc),
    .step_cnt(step_cnt),
    .arg_bad (arg_bad)
  );

  chunk_buf #(
    .DEPTH (BUF_BYTES),
    .DATA_W(DATA_W)
  ) u_buf (
    .clk    (clk),
    .a_idx  (idx_q[IDX_W-1:0]),
    .a_we   (state == S_LOAD && wr_valid),
    .a_wdata(wr_data),
    .a_q    (buf_q),
    .b_idx  (sq_idx),
    .b_we   (sq_we),
    .b_wdata(sq_wdata),
    .b_q    (sq_rdata)
  );

  assign last_idx  = cnt_q - CNT_W'(1);
  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign wr_ready  = (state == S_LOAD);
  assign rd_valid  = (state == S_DRAIN_OUT);
  assign rd_data   = buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= '0;
      addr_q    <= '0;
      remain_q  <= '0;
      chunk_q   <= '0;
      cnt_q     <= '0;
      cyc_q     <= '0;
      idx_q     <= '0;
      cmd_go    <= 1'b0;
      cmd_cycle <= '0;
      cmd_addr  <= '0;
      cmd_count <= '0;
      done      <= 1'b0;
      status    <= ST_OK;
      fail_addr <= '0;
    end else begin
      cmd_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q      <= req_op;
            addr_q    <= req_addr;
            remain_q  <= req_len;
            status    <= ST_OK;
            fail_addr <= '0;
            state     <= S_PLAN;
          end
        end
        S_PLAN: begin
          if (arg_bad) begin
            status <= ST_ARG;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else if (remain_q == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            chunk_q <= step_len;
            cnt_q   <= step_cnt;
            cyc_q   <= step_cyc;
            idx_q   <= '0;
            state   <= (op_q == OP_WRITE) ? S_LOAD : S_ISSUE;
          end
        end
        S_LOAD: begin
          if (wr_valid) begin
            idx_q <= idx_q + CNT_W'(1);
            if (idx_q == last_idx) state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          cmd_go    <= 1'b1;
          cmd_cycle <= cyc_q;
          cmd_addr  <= addr_q;
          cmd_count <= cnt_q;
          state     <= S_WAIT;
        end
        S_WAIT: begin
          if (seq_err) begin
            status    <= ST_DEV;
            fail_addr <= addr_q;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else if (seq_done) begin
            idx_q <= '0;
            state <= (op_q == OP_READ) ? S_DRAIN_RD : S_STEP;
          end
        end
        S_DRAIN_RD: state <= S_DRAIN_OUT;
        S_DRAIN_OUT: begin
          if (rd_ready) begin
            if (idx_q == last_idx) begin
              state <= S_STEP;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
              state <= S_DRAIN_RD;
            end
          end
        end
        S_STEP: begin
          addr_q   <= addr_q + ADDR_W'(chunk_q);
          remain_q <= remain_q - chunk_q;
          state    <= S_PLAN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_chunker_chk.sv
module flash_chunker_chk #(
  parameter int BUF_BYTES   = 64,
  parameter int PAGE_BYTES  = 256,
  parameter int SMALL_ERASE = 4096,
  parameter int BIG_ERASE   = 65536,
  parameter int LO_W        = 16,
  parameter int CNT_W       = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic             cmd_go,
  input logic [1:0]       cmd_cycle,
  input logic [LO_W-1:0]  cmd_lo,
  input logic [CNT_W-1:0] cmd_count,
  input logic             seq_done,
  input logic             seq_err,
  input logic             rd_valid,
  input logic             wr_ready
);
  localparam int PAGE_LG  = $clog2(PAGE_BYTES);
  localparam int SMALL_LG = $clog2(SMALL_ERASE);

  logic pend;
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (cmd_go) pend <= 1'b1;
    else if (seq_done || seq_err) pend <= 1'b0;
  end

  // R1
  count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_cycle < 2'd2) |-> (cmd_count != '0 && int'(cmd_count) <= BUF_BYTES));

  // R1
  page_cross_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_cycle < 2'd2) |->
      (int'(cmd_lo[PAGE_LG-1:0]) + int'(cmd_count) <= PAGE_BYTES));

  // R4
  big_align_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_cycle == 2'd3) |-> (cmd_lo == '0));

  // R4
  small_align_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_cycle == 2'd2) |-> (cmd_lo[SMALL_LG-1:0] == '0));

  // R5
  erase_zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_cycle >= 2'd2) |-> (cmd_count == '0));

  // R10
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> !cmd_go);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && !busy));

  // R8
  rd_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !pend);

  // R7
  load_before_go_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !pend);

endmodule

bind flash_chunker flash_chunker_chk #(
  .BUF_BYTES  (BUF_BYTES),
  .PAGE_BYTES (PAGE_BYTES),
  .SMALL_ERASE(SMALL_ERASE),
  .BIG_ERASE  (BIG_ERASE),
  .LO_W       (LO_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .done     (done),
  .cmd_go   (cmd_go),
  .cmd_cycle(cmd_cycle),
  .cmd_lo   (cmd_addr[LO_W-1:0]),
  .cmd_count(cmd_count),
  .seq_done (seq_done),
  .seq_err  (seq_err),
  .rd_valid (rd_valid),
  .wr_ready (wr_ready)
);

// File: tb/tb_flash_chunker.sv
module tb_flash_chunker;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [23:0] req_addr, req_len;
  logic        wr_valid, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid, rd_ready;
  logic [7:0]  rd_data;
  logic        cmd_go;
  logic [1:0]  cmd_cycle;
  logic [23:0] cmd_addr;
  logic [6:0]  cmd_count;
  logic        seq_done, seq_err;
  logic [5:0]  sq_idx;
  logic        sq_we;
  logic [7:0]  sq_wdata, sq_rdata;
  logic        busy, done;
  logic [1:0]  status;
  logic [23:0] fail_addr;

  always #5 clk = ~clk;

  flash_chunker dut (.*);

  int checks = 0;
  int errors = 0;
  int n_cmd = 0;
  int err_at = -1;
  int log_cyc [64];
  int log_addr[64];
  int log_cnt [64];
  bit pend_tb = 1'b0;
  bit early_rd = 1'b0;
  int wptr = 0;
  int rptr = 0;
  bit feed = 1'b0;
  bit wfire = 1'b0;
  int tick = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sequencer model
  initial begin
    int c, a, n;
    seq_done = 0; seq_err = 0; sq_we = 0; sq_idx = 0; sq_wdata = 0;
    forever begin
      @(negedge clk);
      if (cmd_go) begin
        c = int'(cmd_cycle); a = int'(cmd_addr); n = int'(cmd_count);
        if (n_cmd < 64) begin
          log_cyc[n_cmd] = c; log_addr[n_cmd] = a; log_cnt[n_cmd] = n;
        end
        n_cmd++;
        pend_tb = 1'b1;
        if (c == 1) begin
          for (int i = 0; i < n; i++) begin
            sq_idx = 6'(i);
            @(negedge clk);
            check(sq_rdata == pat(a + i), "R7", sq_rdata, pat(a + i));
          end
        end else if (c == 0) begin
          for (int i = 0; i < n; i++) begin
            sq_we = 1'b1; sq_idx = 6'(i); sq_wdata = pat(a + i);
            @(negedge clk);
          end
          sq_we = 1'b0;
        end
        repeat (2) @(negedge clk);
        pend_tb = 1'b0;
        if (n_cmd - 1 == err_at) seq_err = 1'b1; else seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0; seq_err = 1'b0;
      end
    end
  end

  // write stream source
  initial begin
    wr_valid = 0; wr_data = 0;
    forever begin
      @(negedge clk);
      if (wfire) wptr++;
      wr_valid = feed;
      wr_data  = pat(wptr);
      wfire    = feed && wr_ready;
    end
  end

  // read stream sink with back-pressure
  initial begin
    rd_ready = 0;
    forever begin
      @(negedge clk);
      tick++;
      rd_ready = (tick % 3) != 0;
      if (rd_valid && pend_tb) early_rd = 1'b1;
      if (rd_valid && rd_ready) begin
        check(rd_data == pat(rptr), "R8", rd_data, pat(rptr));
        rptr++;
      end
    end
  end

  task automatic run_req(input int op, input int addr, input int len, input int inj);
    int ecyc[64], eaddr[64], ecnt[64];
    int ne, ea, rem, est, efail, moved, c, off, lat;
    ne = 0; ea = addr; rem = len; est = 0; efail = 0; moved = 0;
    if (op == 3 || (op == 2 && (addr % 4096 != 0 || len % 4096 != 0))) est = 1;
    else begin
      while (rem > 0 && ne < 64) begin
        if (op < 2) begin
          c = (rem < 64) ? rem : 64;
          off = ea % 256;
          if (off != 0 && 256 - off < c) c = 256 - off;
          ecyc[ne] = op; ecnt[ne] = c;
        end else begin
          if (ea % 65536 == 0 && rem >= 65536) begin c = 65536; ecyc[ne] = 3; end
          else begin c = 4096; ecyc[ne] = 2; end
          ecnt[ne] = 0;
        end
        eaddr[ne] = ea;
        if (ne == inj) begin
          est = 2; efail = ea;
          if (op == 1) moved += c;
          ne++;
          break;
        end
        if (op < 2) moved += c;
        ea += c; rem -= c; ne++;
      end
    end
    @(negedge clk);
    n_cmd = 0; err_at = inj; wptr = addr; rptr = addr; wfire = 0; feed = (op == 1);
    req_valid = 1'b1; req_op = op[1:0]; req_addr = 24'(addr); req_len = 24'(len);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 30000) begin
      @(negedge clk);
      lat++;
    end
    feed = 1'b0;
    check(done === 1'b1, "R10", done, 1);
    if (est == 1) check(lat == 1, "R3", lat, 1);
    if (est == 0 && len == 0) check(lat == 1, "R9", lat, 1);
    check(status == 2'(est), (est == 2) ? "R6" : ((est == 1) ? "R3" : "R2"), status, est);
    if (est == 2) check(int'(fail_addr) == efail, "R6", fail_addr, efail);
    check(n_cmd == ne, (est == 2) ? "R6" : "R2", n_cmd, ne);
    for (int i = 0; i < ne && i < n_cmd; i++) begin
      check(log_cyc[i] == ecyc[i], (op == 2) ? "R4" : "R1", log_cyc[i], ecyc[i]);
      check(log_addr[i] == eaddr[i], "R2", log_addr[i], eaddr[i]);
      check(log_cnt[i] == ecnt[i], (op == 2) ? "R5" : "R1", log_cnt[i], ecnt[i]);
    end
    if (op == 0) check(rptr - addr == moved, "R8", rptr - addr, moved);
    if (op == 1) check(wptr - addr == moved, "R7", wptr - addr, moved);
    @(negedge clk);
    check(!busy && req_ready && !done, "R10", busy, 0);
  endtask

  initial begin
    int offs[8];
    int lens[5];
    offs = '{0, 1, 63, 64, 65, 192, 200, 255};
    lens = '{1, 64, 65, 130, 257};
    rst = 1'b1; req_valid = 0; req_op = 0; req_addr = 0; req_len = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(req_ready && !busy && !done && !cmd_go && !wr_ready && !rd_valid, "R10", busy, 0);

    run_req(0, 'h40, 0, -1);          // R9
    run_req(1, 'h77, 0, -1);          // R9
    run_req(0, 'h10, 300, -1);        // R1 R2 R8
    run_req(1, 'hF0, 200, -1);        // R1 R7
    run_req(0, 'hFF, 2, -1);          // R1 page edge
    run_req(0, 'h200, 64, -1);        // R1 aligned
    run_req(1, 'h3C0, 1, -1);         // R1 single byte

    for (int oi = 0; oi < 8; oi++) begin
      for (int li = 0; li < 5; li++) begin
        run_req(0, 'h1000 + offs[oi], lens[li], -1);
        run_req(1, 'h2000 + offs[oi], lens[li], -1);
      end
    end

    run_req(2, 'h10000, 'h24000, -1); // R4 big then small
    run_req(2, 'h3000, 'h1E000, -1);  // R4 small until aligned
    run_req(2, 'h0, 'h10000, -1);     // R4 one big step
    run_req(2, 'h20000, 'hF000, -1);  // R4 length too short for big
    run_req(2, 'h100, 0, -1);         // R3 misaligned, zero length
    run_req(2, 'h100, 'h1000, -1);    // R3 address
    run_req(2, 'h1000, 'h800, -1);    // R3 length
    run_req(3, 'h0, 16, -1);          // R3 illegal op

    run_req(0, 'h10, 300, 2);         // R6 read, third chunk fails
    run_req(1, 'h80, 200, 0);         // R6 write, first chunk fails
    run_req(2, 'h10000, 'h24000, 3);  // R6 erase

    check(!early_rd, "R8", early_rd, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule